// File: doc/BRIEF.md
# Asynchronous Static Memory Read Sequencer

This block turns single host read requests into read cycles on an external asynchronous static memory. For each accepted request it drives an address and byte enables that stay fixed for the whole access. It also drives two active-low strobes: a chip-select strobe and a read-enable strobe. Each strobe has its own delay, width and minimum period, counted in clock cycles. Neither strobe is derived from the other. The access lasts as long as the longer of the two periods. At the end, the host receives the captured word together with a single-cycle valid pulse.

A capture-select input chooses which strobe marks the data sample point. The word is registered on the clock edge that returns the selected strobe high. The other strobe's waveform is never consulted. A zero strobe width is illegal: it raises a configuration error flag and is stretched to one cycle. A period shorter than delay plus width also raises the flag and is stretched to fit. All timing fields are static inputs, sampled at the moment a request is accepted.

Top module: `sram_rd_timing`

## Requirements
- R1: After reset, `mem_cs_n` and `mem_rd_n` are 1, `req_ready` is 1 and `rsp_valid` is 0; both strobes stay 1 whenever no access is in progress.
- R2: Counting the cycle after the accepting clock edge as access cycle 0, `mem_cs_n` is 0 exactly in cycles `cs_setup` to `cs_setup + W - 1`, where W is `cs_pulse`, or 1 when `cs_pulse` is 0.
- R3: `mem_rd_n` follows the same rule with `rd_setup` and `rd_pulse`.
- R4: The access length L is the larger of the two effective periods. Each effective period is the programmed cycle count, raised to setup plus effective width when it is smaller. `rsp_valid` is 1 for exactly one cycle, in access cycle L, which is also the first idle cycle.
- R5: With `rd_ctrl_sel` = 1, `rsp_data` equals the `mem_din` value present in the last cycle in which `mem_rd_n` is 0, whatever `mem_cs_n` does.
- R6: With `rd_ctrl_sel` = 0, `rsp_data` equals the `mem_din` value present in the last cycle in which `mem_cs_n` is 0.
- R7: `cfg_err` is 1 whenever `cs_pulse` or `rd_pulse` is zero.
- R8: `cfg_err` is 1 whenever `cs_cycle < cs_setup + cs_pulse` or `rd_cycle < rd_setup + rd_pulse`; otherwise, with nonzero pulses, it is 0.
- R9: `mem_addr` equals the accepted `req_addr`, and `mem_be_n` equals its bitwise inverse of `req_be`, in every access cycle. `req_ready` is 0 in access cycles 0 to L-1, so no new request is taken before the access completes.
- R10: With zero setups and cycle counts equal to the pulses, both strobes fall in access cycle 0, and the access ends, with `rsp_valid`, in the cycle right after the longer pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Block idle, request taken when both high |
| req_addr | input | ADDR_W | Read address |
| req_be | input | BE_W | Byte enables, active high |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DATA_W | Captured read word |
| cs_setup | input | TIME_W | Chip-select delay in cycles |
| cs_pulse | input | TIME_W | Chip-select width in cycles |
| cs_cycle | input | TIME_W | Chip-select minimum period |
| rd_setup | input | TIME_W | Read-strobe delay in cycles |
| rd_pulse | input | TIME_W | Read-strobe width in cycles |
| rd_cycle | input | TIME_W | Read-strobe minimum period |
| rd_ctrl_sel | input | 1 | 1: read strobe picks sample point, 0: chip select |
| cfg_err | output | 1 | Illegal timing configuration |
| mem_addr | output | ADDR_W | Memory address |
| mem_be_n | output | BE_W | Active-low byte enables |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_rd_n | output | 1 | Active-low read enable |
| mem_din | input | DATA_W | Memory read data |

## Verification
A corrupted step counter or latched window shows up as a strobe edge in the wrong access cycle. It also makes the response pulse arrive early or late against L, so the per-cycle strobe trace exposes it within the faulty access. The bench's memory model gives valid data only a fixed number of cycles after the read strobe falls. A capture point shifted by even one cycle therefore returns the invalid marker instead of the addressed word. It does this in the same access. Configurations are chosen so the two strobes end at different cycles, which makes the two capture-select settings distinguishable.

// File: rtl/srt_pkg.sv
package srt_pkg;

    parameter int unsigned TIME_W = 5;
    localparam int unsigned CNT_W = TIME_W + 1;

    localparam int unsigned N_STROBE = 2;
    localparam int unsigned IDX_CS   = 0;
    localparam int unsigned IDX_RD   = 1;

    typedef logic [TIME_W-1:0] tfield_t;
    typedef logic [CNT_W-1:0]  tcount_t;

    typedef struct packed {
        tfield_t setup;
        tfield_t pulse;
        tfield_t cycle;
    } strobe_cfg_t;

    // start: first low cycle, stop: first high cycle after the pulse,
    // length: effective period of this strobe
    typedef struct packed {
        tcount_t start;
        tcount_t stop;
        tcount_t length;
    } strobe_win_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_t;

    typedef enum logic {
        CAP_BY_CS = 1'b0,
        CAP_BY_RD = 1'b1
    } cap_sel_t;

    function automatic tcount_t widen(input tfield_t v);
        return {1'b0, v};
    endfunction

    function automatic tcount_t tmax(input tcount_t a, input tcount_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic pulse_bad(input strobe_cfg_t c);
        return (c.pulse == '0);
    endfunction

    function automatic logic cycle_bad(input strobe_cfg_t c);
        return (widen(c.cycle) < (widen(c.setup) + widen(c.pulse)));
    endfunction

    function automatic strobe_win_t resolve(input strobe_cfg_t c);
        strobe_win_t w;
        tcount_t     p;
        p        = (c.pulse == '0) ? tcount_t'(1) : widen(c.pulse);
        w.start  = widen(c.setup);
        w.stop   = widen(c.setup) + p;
        w.length = tmax(widen(c.cycle), w.stop);
        return w;
    endfunction

endpackage

// File: rtl/srt_cfg_resolve.sv
module srt_cfg_resolve
    import srt_pkg::*;
(
    input  strobe_cfg_t [N_STROBE-1:0] cfg,
    output strobe_win_t [N_STROBE-1:0] win,
    output tcount_t                    total_len,
    output logic                       cfg_err
);

    logic    [N_STROBE-1:0] err_vec;
    tcount_t [N_STROBE-1:0] len_vec;

    for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
        always_comb begin
            win[g]     = resolve(cfg[g]);
            err_vec[g] = pulse_bad(cfg[g]) | cycle_bad(cfg[g]);
            len_vec[g] = win[g].length;
        end
    end

    always_comb begin
        total_len = '0;
        for (int i = 0; i < N_STROBE; i++) begin
            total_len = tmax(total_len, len_vec[i]);
        end
        cfg_err = |err_vec;
    end

endmodule

// File: rtl/srt_seq.sv
module srt_seq
    import srt_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  strobe_win_t [N_STROBE-1:0] win_in,
    input  tcount_t                    len_in,
    input  logic                       sel_in,
    output logic                       accept,
    output logic                       busy,
    output logic                       last,
    output tcount_t                    cur_cnt,
    output logic                       nxt_busy,
    output tcount_t                    nxt_cnt,
    output strobe_win_t [N_STROBE-1:0] win_use,
    output cap_sel_t                   sel_q
);

    seq_state_t                 state_q;
    tcount_t                    cnt_q;
    tcount_t                    len_q;
    strobe_win_t [N_STROBE-1:0] win_q;

    assign busy    = (state_q == SEQ_BUSY);
    assign accept  = (state_q == SEQ_IDLE) && req_valid;
    assign last    = busy && (cnt_q == len_q - tcount_t'(1));
    assign cur_cnt = cnt_q;

    always_comb begin
        nxt_busy = accept || (busy && !last);
        if (accept) begin
            nxt_cnt = '0;
        end else if (busy && !last) begin
            nxt_cnt = cnt_q + tcount_t'(1);
        end else begin
            nxt_cnt = '0;
        end
        win_use = accept ? win_in : win_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            len_q   <= tcount_t'(1);
            win_q   <= '0;
            sel_q   <= CAP_BY_RD;
        end else begin
            state_q <= nxt_busy ? SEQ_BUSY : SEQ_IDLE;
            cnt_q   <= nxt_cnt;
            if (accept) begin
                len_q <= len_in;
                win_q <= win_in;
                sel_q <= cap_sel_t'(sel_in);
            end
        end
    end

    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q < len_q));

    a_r4_ends_idle: assert property (@(posedge clk) disable iff (rst)
        last |=> (state_q == SEQ_IDLE));

endmodule

// File: rtl/srt_strobe.sv
module srt_strobe
    import srt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    nxt_busy,
    input  tcount_t nxt_cnt,
    input  tcount_t start,
    input  tcount_t stop,
    input  logic    busy,
    input  tcount_t cur_cnt,
    input  tcount_t cur_start,
    input  tcount_t cur_stop,
    output logic    strobe_n
);

    logic low_next;

    assign low_next = nxt_busy && (nxt_cnt >= start) && (nxt_cnt < stop);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_n <= 1'b1;
        end else begin
            strobe_n <= !low_next;
        end
    end

    // R2/R3: the strobe is low only inside its programmed window
    a_r2_low_in_window: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> (busy && (cur_cnt >= cur_start) && (cur_cnt < cur_stop)));

endmodule

// File: rtl/srt_capture.sv
module srt_capture
    import srt_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              last,
    input  tcount_t           cur_cnt,
    input  tcount_t           ctrl_stop,
    input  logic              ctrl_strobe_n,
    input  logic [DATA_W-1:0] mem_din,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    logic cap_fire;

    assign cap_fire = busy && (cur_cnt == ctrl_stop - tcount_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= last;
            if (cap_fire) begin
                rsp_data <= mem_din;
            end
        end
    end

    a_r5_capture_while_low: assert property (@(posedge clk) disable iff (rst)
        cap_fire |-> !ctrl_strobe_n);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_rd_timing.sv
module sram_rd_timing
    import srt_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic [TIME_W-1:0] cs_setup,
    input  logic [TIME_W-1:0] cs_pulse,
    input  logic [TIME_W-1:0] cs_cycle,
    input  logic [TIME_W-1:0] rd_setup,
    input  logic [TIME_W-1:0] rd_pulse,
    input  logic [TIME_W-1:0] rd_cycle,
    input  logic              rd_ctrl_sel,
    output logic              cfg_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_be_n,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    input  logic [DATA_W-1:0] mem_din
);

    strobe_cfg_t [N_STROBE-1:0] cfg;
    strobe_win_t [N_STROBE-1:0] win_in;
    strobe_win_t [N_STROBE-1:0] win_use;
    tcount_t                    len_in;
    logic                       accept;
    logic                       busy;
    logic                       last;
    logic                       nxt_busy;
    tcount_t                    cur_cnt;
    tcount_t                    nxt_cnt;
    cap_sel_t                   sel_q;
    logic [N_STROBE-1:0]        strobe_n;
    logic [BE_W-1:0]            be_q;
    logic                       ctrl_strobe_n;
    tcount_t                    ctrl_stop;

    assign cfg[IDX_CS] = '{setup: cs_setup, pulse: cs_pulse, cycle: cs_cycle};
    assign cfg[IDX_RD] = '{setup: rd_setup, pulse: rd_pulse, cycle: rd_cycle};

    srt_cfg_resolve u_cfg (
        .cfg       (cfg),
        .win       (win_in),
        .total_len (len_in),
        .cfg_err   (cfg_err)
    );

    srt_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .win_in    (win_in),
        .len_in    (len_in),
        .sel_in    (rd_ctrl_sel),
        .accept    (accept),
        .busy      (busy),
        .last      (last),
        .cur_cnt   (cur_cnt),
        .nxt_busy  (nxt_busy),
        .nxt_cnt   (nxt_cnt),
        .win_use   (win_use),
        .sel_q     (sel_q)
    );

    for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
        srt_strobe u_strobe (
            .clk       (clk),
            .rst       (rst),
            .nxt_busy  (nxt_busy),
            .nxt_cnt   (nxt_cnt),
            .start     (win_use[g].start),
            .stop      (win_use[g].stop),
            .busy      (busy),
            .cur_cnt   (cur_cnt),
            .cur_start (win_use[g].start),
            .cur_stop  (win_use[g].stop),
            .strobe_n  (strobe_n[g])
        );
    end

    assign mem_cs_n = strobe_n[IDX_CS];
    assign mem_rd_n = strobe_n[IDX_RD];

    always_comb begin
        if (sel_q == CAP_BY_RD) begin
            ctrl_strobe_n = strobe_n[IDX_RD];
            ctrl_stop     = win_use[IDX_RD].stop;
        end else begin
            ctrl_strobe_n = strobe_n[IDX_CS];
            ctrl_stop     = win_use[IDX_CS].stop;
        end
    end

    srt_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk           (clk),
        .rst           (rst),
        .busy          (busy),
        .last          (last),
        .cur_cnt       (cur_cnt),
        .ctrl_stop     (ctrl_stop),
        .ctrl_strobe_n (ctrl_strobe_n),
        .mem_din       (mem_din),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            be_q     <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            be_q     <= req_be;
        end
    end

    assign mem_be_n  = busy ? ~be_q : '1;
    assign req_ready = !busy;

    a_r1_idle_strobes_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_cs_n && mem_rd_n));

    a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

    a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy);

endmodule

// File: tb/sram_rd_timing_tb.sv
module sram_rd_timing_tb;
    import srt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int BE_W   = 2;
    localparam int ACC    = 2;
    localparam logic [DATA_W-1:0] INVALID = 16'hDEAD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [BE_W-1:0]   req_be = '0;
    logic rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [TIME_W-1:0] cs_setup = '0, cs_pulse = 5'd1, cs_cycle = 5'd1;
    logic [TIME_W-1:0] rd_setup = '0, rd_pulse = 5'd1, rd_cycle = 5'd1;
    logic rd_ctrl_sel = 1'b1;
    logic cfg_err;
    logic [ADDR_W-1:0] mem_addr;
    logic [BE_W-1:0]   mem_be_n;
    logic mem_cs_n, mem_rd_n;
    logic [DATA_W-1:0] mem_din;

    int checks = 0;
    int failures = 0;
    int lowcnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_rd_timing #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_be(req_be), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .cs_setup(cs_setup), .cs_pulse(cs_pulse),
        .cs_cycle(cs_cycle), .rd_setup(rd_setup), .rd_pulse(rd_pulse),
        .rd_cycle(rd_cycle), .rd_ctrl_sel(rd_ctrl_sel), .cfg_err(cfg_err),
        .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_cs_n(mem_cs_n),
        .mem_rd_n(mem_rd_n), .mem_din(mem_din)
    );

    // memory model: data valid ACC cycles after the read strobe falls
    always @(posedge clk) lowcnt <= mem_rd_n ? 0 : lowcnt + 1;

    function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
        return {4'h1, a};
    endfunction

    always @* mem_din = (!mem_rd_n && lowcnt >= ACC) ? pat(mem_addr) : INVALID;

    function automatic int eff_p(input int p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic int eff_c(input int s, input int p, input int c);
        return (c < s + eff_p(p)) ? s + eff_p(p) : c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_read(input int css, input int csp, input int csc,
                            input int rds, input int rdp, input int rdc,
                            input bit sel, input logic [ADDR_W-1:0] a,
                            input logic [BE_W-1:0] be, input bit tag10);
        int len, idx, cs_first, cs_cnt, rd_first, rd_cnt, e;
        bit addr_ok, ready_ok, err_exp, dval;
        logic [DATA_W-1:0] exp_data;
        cs_setup = TIME_W'(css); cs_pulse = TIME_W'(csp); cs_cycle = TIME_W'(csc);
        rd_setup = TIME_W'(rds); rd_pulse = TIME_W'(rdp); rd_cycle = TIME_W'(rdc);
        rd_ctrl_sel = sel; req_addr = a; req_be = be;
        len = eff_c(css, csp, csc);
        if (eff_c(rds, rdp, rdc) > len) len = eff_c(rds, rdp, rdc);
        err_exp = (csp == 0) || (rdp == 0) || (csc < css + csp) || (rdc < rds + rdp);
        #1;
        if ((csp == 0) || (rdp == 0))
            check(cfg_err == err_exp, "R7", int'(cfg_err), int'(err_exp));
        else
            check(cfg_err == err_exp, "R8", int'(cfg_err), int'(err_exp));
        check(req_ready == 1'b1, "R9", int'(req_ready), 1);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cs_first = -1; rd_first = -1; cs_cnt = 0; rd_cnt = 0;
        addr_ok = 1; ready_ok = 1; idx = 0;
        while (!rsp_valid && idx < 100) begin
            if (!mem_cs_n) begin if (cs_first < 0) cs_first = idx; cs_cnt++; end
            if (!mem_rd_n) begin if (rd_first < 0) rd_first = idx; rd_cnt++; end
            if (mem_addr !== a || mem_be_n !== ~be) addr_ok = 0;
            if (req_ready) ready_ok = 0;
            idx++;
            @(negedge clk);
        end
        check(idx == len, "R4", idx, len);
        check(cs_first == css && cs_cnt == eff_p(csp), "R2",
              cs_first * 100 + cs_cnt, css * 100 + eff_p(csp));
        check(rd_first == rds && rd_cnt == eff_p(rdp), "R3",
              rd_first * 100 + rd_cnt, rds * 100 + eff_p(rdp));
        check(addr_ok && ready_ok, "R9", int'(addr_ok) * 2 + int'(ready_ok), 3);
        e = sel ? rds + eff_p(rdp) - 1 : css + eff_p(csp) - 1;
        dval = (e >= rds) && (e < rds + eff_p(rdp)) && (e - rds >= ACC);
        exp_data = dval ? pat(a) : INVALID;
        if (sel) check(rsp_data == exp_data, "R5", int'(rsp_data), int'(exp_data));
        else     check(rsp_data == exp_data, "R6", int'(rsp_data), int'(exp_data));
        if (tag10) begin
            check(cs_first == 0 && rd_first == 0 && idx == len, "R10",
                  cs_first * 100 + idx, len);
        end
        @(negedge clk);
        check(!rsp_valid && mem_cs_n && mem_rd_n, "R4", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(mem_cs_n && mem_rd_n && req_ready && !rsp_valid, "R1",
              {mem_cs_n, mem_rd_n, req_ready, rsp_valid}, 4'b1110);
        // R10 zero setup, zero hold, both modes
        run_read(0, 3, 3, 0, 3, 3, 1'b1, 12'h0A1, 2'b11, 1'b1);
        run_read(0, 4, 4, 0, 4, 4, 1'b0, 12'h0A2, 2'b01, 1'b1);
        // R5 read strobe ends before chip select
        run_read(0, 8, 8, 1, 4, 5, 1'b1, 12'h123, 2'b10, 1'b0);
        // R6 chip select ends before read strobe valid window closes
        run_read(0, 5, 9, 1, 7, 8, 1'b0, 12'h456, 2'b11, 1'b0);
        // R6 chip select ends too early: invalid marker captured
        run_read(0, 2, 2, 0, 6, 6, 1'b0, 12'h789, 2'b11, 1'b0);
        // R7 zero pulses
        run_read(1, 0, 4, 0, 0, 2, 1'b1, 12'h321, 2'b01, 1'b0);
        // R8 short cycles
        run_read(2, 3, 1, 1, 4, 2, 1'b1, 12'h654, 2'b10, 1'b0);
        // back-to-back (R9 ready behaviour)
        run_read(1, 3, 6, 0, 5, 5, 1'b1, 12'h777, 2'b11, 1'b0);
        for (int i = 0; i < 40; i++) begin
            run_read($urandom_range(0, 4), $urandom_range(0, 5), $urandom_range(0, 14),
                     $urandom_range(0, 4), $urandom_range(0, 6), $urandom_range(0, 14),
                     1'($urandom_range(0, 1)), ADDR_W'($urandom),
                     BE_W'($urandom), 1'b0);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule